// File: doc/BRIEF.md
# Stipple and Blit Drawing Engine

This block accelerates simple drawing into an 8-bit indexed frame buffer whose lines are 1024 pixels long. Software drives it through a 32-bit write window. A write to an even word holds a colour for later use. A write to an odd word starts a drawing operation. The destination pixel address of that operation comes from the access offset. A window select picks the kind of operation. A stipple paints the held colour under a 32-bit mask. A blit either copies a run of pixels or fills the run with the held colour. A single data word selects between copy and fill and also carries the run length.

The engine reaches pixel memory through a synchronous single-byte port and makes at most one access per clock. A read request returns its data in the next cycle. While an operation runs, `busy` is high and a further start write is stalled through `reg_ready`. Colour writes are never stalled. When an operation completes, a one-cycle dirty report gives the destination start and the length of the span it touched, so that scan-out logic can refresh that span.

Top module: `stip_blit_engine`

## Requirements
- R1: A write with `reg_addr[2]` = 0 stores `reg_wdata[7:0]` as the pending colour. It is accepted in the same cycle even while busy (`reg_ready` = 1), causes no pixel-memory access and does not change the frame buffer.
- R2: A write with `reg_addr[2]` = 1 starts an operation at destination pixel address `reg_addr[22:3]`. `reg_win` = 0 selects a stipple and `reg_win` = 1 selects a blit.
- R3: A stipple covers 32 pixels, one per cycle. Mask bit `reg_wdata[31-i]` governs pixel dst+i. Each pixel whose bit is 1 is written with the colour. Each pixel whose bit is 0 gets no access and keeps its value. Completion is reported 33 cycles after acceptance.
- R4: A blit's run length is `reg_wdata[28:24]` + 1, which gives 1 to 32 pixels.
- R5: A blit with `reg_wdata[23:0]` = 0xFFFFFF fills the run with the colour, one write per cycle. Completion is reported length + 1 cycles after acceptance.
- R6: Any other blit copies byte by byte in ascending order. The source is `reg_wdata[19:0]`; bits 23:20 are ignored except for the fill code. Each pixel i is read from src+i in one cycle and written to dst+i in the next. An overlapping forward copy therefore repeats the source pattern. Completion is reported 2·length + 1 cycles after acceptance.
- R7: `reg_rdata` reads as zero at all times.
- R8: `busy` rises in the cycle after a start is accepted and falls when the operation ends. A start write presented while busy sees `reg_ready` = 0 and is accepted in the first cycle after `busy` falls.
- R9: On completion, `dirty_valid` pulses for one cycle with `dirty_addr` set to the destination start and `dirty_len` set to the length: 32 for a stipple, or the run length for a blit.
- R10: After reset `busy`, `dirty_valid` and `pm_req` are 0. `pm_req` is never high while idle. Pixel addresses wrap modulo 2^20.
- R11: An operation uses the colour that was pending when it was accepted. Colour writes made during the operation affect only later operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_win | input | 1 | Window select: 0 stipple, 1 blit |
| reg_addr | input | 23 | Byte offset inside the window |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Write accepted this cycle |
| reg_rdata | output | 32 | Read data, always zero |
| pm_req | output | 1 | Pixel-memory access request |
| pm_we | output | 1 | 1 write, 0 read |
| pm_addr | output | 20 | Pixel address |
| pm_wdata | output | 8 | Pixel write data |
| pm_rdata | input | 8 | Pixel read data, valid the cycle after a read |
| busy | output | 1 | Operation in progress |
| dirty_valid | output | 1 | One-cycle completion report |
| dirty_addr | output | 20 | Destination start of the finished operation |
| dirty_len | output | 6 | Pixel count of the finished operation |

## Verification
A wrong step counter or wrong state in the sequencer shows up at the ports in two ways. The completion pulse arrives in the wrong cycle, and the count of memory writes and reads differs from the mask population or the run length. Both are visible within one operation of at most 65 cycles. A bad mask shift, address offset or colour snapshot leaves a mismatch in the frame buffer. That mismatch is found by comparing the whole buffer with an independent model right after the dirty pulse. Errors in the stall handshake appear as a wrong stall count on the very next start write.

// File: rtl/sbe_pkg.sv
// Shared constants and types for the stipple/blit engine.
// Assumes an 8-bit pixel, a 20-bit pixel address space and a 32-pixel mask.
package sbe_pkg;
    localparam int PIX_W       = 8;
    localparam int PIX_AW      = 20;
    localparam int DATA_W      = 32;
    localparam int MASK_W      = 32;
    localparam int SRC_W       = 24;
    localparam int LEN_LSB     = 24;
    localparam int LEN_FIELD_W = $clog2(MASK_W);
    localparam int LEN_W       = LEN_FIELD_W + 1;
    localparam int SEL_BIT     = 2;
    localparam int DST_LSB     = 3;
    localparam int OFS_W       = PIX_AW + DST_LSB;

    typedef enum logic [1:0] {
        OP_STIP = 2'd0,
        OP_FILL = 2'd1,
        OP_COPY = 2'd2
    } sbe_op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_STIP = 3'd1,
        S_FILL = 3'd2,
        S_CRD  = 3'd3,
        S_CWR  = 3'd4
    } sbe_state_e;

    typedef struct packed {
        sbe_op_e                op;
        logic [PIX_AW-1:0]      dst;
        logic [PIX_AW-1:0]      src;
        logic [LEN_W-1:0]       len;
        logic [MASK_W-1:0]      mask;
        logic [PIX_W-1:0]       colour;
    } sbe_cmd_t;
endpackage

// File: rtl/sbe_regif.sv
// Register-window decode: holds the pending colour, builds a command from a
// start write and stalls start writes while the sequencer is busy.
// Assumes single-cycle writes and that colour writes are always accepted.
module sbe_regif
    import sbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_win,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    output logic              reg_ready,
    output logic              start,
    output sbe_cmd_t          cmd
);
    logic [PIX_W-1:0] colour_q;
    logic             is_start;
    logic [SRC_W-1:0] src_field;
    logic             fill_code;
    logic             unused_ofs;

    assign unused_ofs = ^reg_addr[SEL_BIT-1:0];
    assign is_start   = reg_wr & reg_addr[SEL_BIT];
    assign reg_ready  = ~(is_start & busy);
    assign start      = is_start & ~busy;

    // Pending colour register, updated by even-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colour_q <= '0;
        end else if (reg_wr && !reg_addr[SEL_BIT]) begin
            colour_q <= reg_wdata[PIX_W-1:0];
        end
    end

    // Command fields decoded from the start write.
    always_comb begin
        src_field  = reg_wdata[SRC_W-1:0];
        fill_code  = &src_field;
        cmd.op     = !reg_win ? OP_STIP : (fill_code ? OP_FILL : OP_COPY);
        cmd.dst    = reg_addr[DST_LSB +: PIX_AW];
        cmd.src    = src_field[PIX_AW-1:0];
        cmd.len    = reg_win ? (LEN_W'(reg_wdata[LEN_LSB +: LEN_FIELD_W]) + LEN_W'(1))
                             : LEN_W'(MASK_W);
        cmd.mask   = reg_wdata[MASK_W-1:0];
        cmd.colour = colour_q;
    end
endmodule

// File: rtl/sbe_seq.sv
// Operation sequencer: steps through one pixel per cycle, issues the
// pixel-memory accesses and flags the final step.
// Assumes pm_rdata is valid the cycle after a read request.
module sbe_seq
    import sbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  sbe_cmd_t          cmd,
    input  logic [PIX_W-1:0]  pm_rdata,
    output logic              pm_req,
    output logic              pm_we,
    output logic [PIX_AW-1:0] pm_addr,
    output logic [PIX_W-1:0]  pm_wdata,
    output logic              busy,
    output logic              done,
    output logic [PIX_AW-1:0] done_dst,
    output logic [LEN_W-1:0]  done_len
);
    sbe_state_e        state_q;
    sbe_cmd_t          cmd_q;
    logic [LEN_W-1:0]  idx_q;
    logic [PIX_AW-1:0] off;
    logic [PIX_AW-1:0] dst_addr;
    logic [PIX_AW-1:0] src_addr;
    logic              last_run;
    logic              step_end;

    // Maps an operation kind to its first sequencer state.
    function automatic sbe_state_e first_state(input sbe_op_e op);
        case (op)
            OP_STIP: first_state = S_STIP;
            OP_FILL: first_state = S_FILL;
            default: first_state = S_CRD;
        endcase
    endfunction

    // Access generation for the current step.
    always_comb begin
        off      = PIX_AW'(idx_q);
        dst_addr = cmd_q.dst + off;
        src_addr = cmd_q.src + off;
        last_run = (idx_q == (cmd_q.len - LEN_W'(1)));
        pm_req   = 1'b0;
        pm_we    = 1'b0;
        pm_addr  = dst_addr;
        pm_wdata = cmd_q.colour;
        step_end = 1'b0;
        case (state_q)
            S_STIP: begin
                pm_req   = cmd_q.mask[MASK_W-1];
                pm_we    = 1'b1;
                step_end = last_run;
            end
            S_FILL: begin
                pm_req   = 1'b1;
                pm_we    = 1'b1;
                step_end = last_run;
            end
            S_CRD: begin
                pm_req  = 1'b1;
                pm_addr = src_addr;
            end
            S_CWR: begin
                pm_req   = 1'b1;
                pm_we    = 1'b1;
                pm_wdata = pm_rdata;
                step_end = last_run;
            end
            default: begin
                pm_req = 1'b0;
            end
        endcase
    end

    // State, step index and captured command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            cmd_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        cmd_q   <= cmd;
                        idx_q   <= '0;
                        state_q <= first_state(cmd.op);
                    end
                end
                S_STIP: begin
                    cmd_q.mask <= cmd_q.mask << 1;
                    if (step_end) state_q <= S_IDLE;
                    else          idx_q   <= idx_q + LEN_W'(1);
                end
                S_FILL: begin
                    if (step_end) state_q <= S_IDLE;
                    else          idx_q   <= idx_q + LEN_W'(1);
                end
                S_CRD: begin
                    state_q <= S_CWR;
                end
                S_CWR: begin
                    if (step_end) begin
                        state_q <= S_IDLE;
                    end else begin
                        idx_q   <= idx_q + LEN_W'(1);
                        state_q <= S_CRD;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != S_IDLE);
    assign done     = step_end;
    assign done_dst = cmd_q.dst;
    assign done_len = cmd_q.len;
endmodule

// File: rtl/sbe_dirty.sv
// Dirty-range reporter: registers the span of an operation as it completes
// and presents it for exactly one cycle.
// Assumes done is a single-cycle pulse from the sequencer.
module sbe_dirty
    import sbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [PIX_AW-1:0] done_dst,
    input  logic [LEN_W-1:0]  done_len,
    output logic              dirty_valid,
    output logic [PIX_AW-1:0] dirty_addr,
    output logic [LEN_W-1:0]  dirty_len
);
    // Capture span on completion; the valid flag lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_valid <= 1'b0;
            dirty_addr  <= '0;
            dirty_len   <= '0;
        end else begin
            dirty_valid <= done;
            if (done) begin
                dirty_addr <= done_dst;
                dirty_len  <= done_len;
            end
        end
    end
endmodule

// File: rtl/stip_blit_engine.sv
// Top of the stipple/blit drawing engine: register decode, sequencer and
// dirty reporter. Reads of the window return zero.
// Assumes a synchronous one-byte pixel memory with one-cycle read latency.
module stip_blit_engine
    import sbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_win,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_ready,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pm_req,
    output logic              pm_we,
    output logic [PIX_AW-1:0] pm_addr,
    output logic [PIX_W-1:0]  pm_wdata,
    input  logic [PIX_W-1:0]  pm_rdata,
    output logic              busy,
    output logic              dirty_valid,
    output logic [PIX_AW-1:0] dirty_addr,
    output logic [LEN_W-1:0]  dirty_len
);
    logic              start;
    sbe_cmd_t          cmd;
    logic              done;
    logic [PIX_AW-1:0] done_dst;
    logic [LEN_W-1:0]  done_len;

    assign reg_rdata = '0;

    sbe_regif u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_win   (reg_win),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .reg_ready (reg_ready),
        .start     (start),
        .cmd       (cmd)
    );

    sbe_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .pm_rdata (pm_rdata),
        .pm_req   (pm_req),
        .pm_we    (pm_we),
        .pm_addr  (pm_addr),
        .pm_wdata (pm_wdata),
        .busy     (busy),
        .done     (done),
        .done_dst (done_dst),
        .done_len (done_len)
    );

    sbe_dirty u_dirty (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .done_dst    (done_dst),
        .done_len    (done_len),
        .dirty_valid (dirty_valid),
        .dirty_addr  (dirty_addr),
        .dirty_len   (dirty_len)
    );
endmodule

// File: rtl/sbe_checker.sv
// Port-level protocol checks for the stipple/blit engine, bound to the top.
module sbe_checker
    import sbe_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [OFS_W-1:0] reg_addr,
    input logic             reg_ready,
    input logic             pm_req,
    input logic             pm_we,
    input logic             busy,
    input logic             dirty_valid,
    input logic [LEN_W-1:0] dirty_len
);
    p_colour_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr[SEL_BIT]) |-> reg_ready);

    p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr[SEL_BIT]) |-> !reg_ready);

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[SEL_BIT] && reg_ready) |=> busy);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pm_req);

    p_dirty_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |-> (!busy && $past(busy)));

    p_fall_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> dirty_valid);

    p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |-> (dirty_len != '0 && dirty_len <= LEN_W'(MASK_W)));

    p_copy_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_req && !pm_we) |=> (pm_req && pm_we));
endmodule

bind stip_blit_engine sbe_checker u_sbe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_ready   (reg_ready),
    .pm_req      (pm_req),
    .pm_we       (pm_we),
    .busy        (busy),
    .dirty_valid (dirty_valid),
    .dirty_len   (dirty_len)
);

// File: tb/stip_blit_engine_test.sv
`timescale 1ns/1ps
module stip_blit_engine_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic        reg_win;
    logic [22:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_ready;
    logic [31:0] reg_rdata;
    logic        pm_req;
    logic        pm_we;
    logic [19:0] pm_addr;
    logic [7:0]  pm_wdata;
    logic [7:0]  pm_rdata;
    logic        busy;
    logic        dirty_valid;
    logic [19:0] dirty_addr;
    logic [5:0]  dirty_len;

    always #10 clk = ~clk;

    stip_blit_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_win(reg_win),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
        .reg_rdata(reg_rdata), .pm_req(pm_req), .pm_we(pm_we),
        .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
        .busy(busy), .dirty_valid(dirty_valid), .dirty_addr(dirty_addr),
        .dirty_len(dirty_len)
    );

    logic [7:0] mem [0:4095];
    logic [7:0] exp_mem [0:4095];
    int wr_cnt;
    int rd_cnt;
    int checks;
    int fails;

    // Pixel memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (pm_req) begin
            if (pm_we) begin
                mem[pm_addr[11:0]] <= pm_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                pm_rdata <= mem[pm_addr[11:0]];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int mem_diff();
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== exp_mem[i]) return i;
        return -1;
    endfunction

    task automatic chk_mem(input string req);
        int d;
        d = mem_diff();
        if (d < 0) chk(1'b1, req, "frame buffer", 0, 0);
        else chk(1'b0, req, $sformatf("pixel %0h", d), mem[d], exp_mem[d]);
    endtask

    function automatic int pix(input int a);
        return (a & 20'hFFFFF) & 12'hFFF;
    endfunction

    task automatic m_stip(input int dst, input logic [31:0] mask, input logic [7:0] c);
        for (int i = 0; i < 32; i++)
            if (mask[31-i]) exp_mem[pix(dst + i)] = c;
    endtask

    task automatic m_fill(input int dst, input int len, input logic [7:0] c);
        for (int i = 0; i < len; i++) exp_mem[pix(dst + i)] = c;
    endtask

    task automatic m_copy(input int dst, input int src, input int len);
        for (int i = 0; i < len; i++) exp_mem[pix(dst + i)] = exp_mem[pix(src + i)];
    endtask

    task automatic bus_wr(input bit win, input logic [22:0] a, input logic [31:0] d,
                          output int stalls);
        stalls = 0;
        @(negedge clk);
        reg_wr = 1'b1; reg_win = win; reg_addr = a; reg_wdata = d;
        #1;
        while (!reg_ready && stalls < 1000) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!dirty_valid && cyc < 500);
    endtask

    task automatic set_colour(input logic [7:0] c);
        int s;
        bus_wr(1'b0, 23'h0, {24'hABCDE0, c}, s);
    endtask

    task automatic t_reset();
        chk(busy === 1'b0, "R10", "busy after reset", busy, 0);
        chk(dirty_valid === 1'b0, "R10", "dirty after reset", dirty_valid, 0);
        chk(pm_req === 1'b0, "R10", "pm_req after reset", pm_req, 0);
        chk(reg_rdata === 32'h0, "R7", "rdata after reset", reg_rdata, 0);
    endtask

    task automatic t_colour_only();
        int s;
        wr_cnt = 0; rd_cnt = 0;
        bus_wr(1'b0, {20'h00123, 3'b000}, 32'h123456AB, s);
        bus_wr(1'b1, {20'h00456, 3'b000}, 32'h0000005A, s);
        repeat (3) @(negedge clk);
        chk(wr_cnt + rd_cnt == 0, "R1", "accesses after colour writes", wr_cnt + rd_cnt, 0);
        chk(busy === 1'b0, "R1", "busy after colour writes", busy, 0);
        chk_mem("R1");
    endtask

    task automatic t_stipple(input int dst, input logic [31:0] mask, input logic [7:0] c);
        int s, cyc;
        set_colour(c);
        wr_cnt = 0;
        bus_wr(1'b0 ^ 1'b0, {dst[19:0], 3'b100}, mask, s);
        m_stip(dst, mask, c);
        wait_done(cyc);
        chk(cyc == 33, "R3", "stipple completion cycle", cyc, 33);
        chk(wr_cnt == $countones(mask), "R3", "stipple writes", wr_cnt, $countones(mask));
        chk(dirty_addr == dst[19:0], "R9", "stipple dirty addr", dirty_addr, dst[19:0]);
        chk(dirty_len == 6'd32, "R9", "stipple dirty len", dirty_len, 32);
        chk_mem("R3");
        @(negedge clk);
        chk(dirty_valid === 1'b0, "R9", "dirty pulse width", dirty_valid, 0);
    endtask

    task automatic t_fill(input int dst, input int len, input logic [7:0] c);
        int s, cyc;
        set_colour(c);
        wr_cnt = 0;
        bus_wr(1'b1, {dst[19:0], 3'b100}, {3'b000, 5'(len - 1), 24'hFFFFFF}, s);
        m_fill(dst, len, c);
        wait_done(cyc);
        chk(cyc == len + 1, "R5", "fill completion cycle", cyc, len + 1);
        chk(wr_cnt == len, "R4", "fill writes", wr_cnt, len);
        chk(dirty_len == 6'(len), "R4", "fill dirty len", dirty_len, len);
        chk(dirty_addr == dst[19:0], "R2", "fill dirty addr", dirty_addr, dst[19:0]);
        chk_mem("R5");
    endtask

    task automatic t_copy(input int dst, input logic [23:0] src, input int len);
        int s, cyc;
        wr_cnt = 0; rd_cnt = 0;
        bus_wr(1'b1, {dst[19:0], 3'b100}, {3'b111, 5'(len - 1), src}, s);
        m_copy(dst, int'(src[19:0]), len);
        wait_done(cyc);
        chk(cyc == 2 * len + 1, "R6", "copy completion cycle", cyc, 2 * len + 1);
        chk(rd_cnt == len && wr_cnt == len, "R6", "copy reads+writes", rd_cnt + wr_cnt, 2 * len);
        chk(dirty_len == 6'(len), "R4", "copy dirty len", dirty_len, len);
        chk_mem("R6");
    endtask

    task automatic t_busy_colour();
        int s, cyc;
        set_colour(8'hC1);
        bus_wr(1'b0, {20'h00800, 3'b100}, 32'hAAAA5555, s);
        bus_wr(1'b0, 23'h0, 32'h000000D2, s);
        chk(s == 0, "R1", "colour write stall while busy", s, 0);
        chk(busy === 1'b1, "R1", "still busy after colour write", busy, 1);
        chk(reg_rdata === 32'h0, "R7", "rdata while busy", reg_rdata, 0);
        m_stip(32'h800, 32'hAAAA5555, 8'hC1);
        wait_done(cyc);
        chk_mem("R11");
        bus_wr(1'b1, {20'h00840, 3'b100}, {3'b000, 5'd3, 24'hFFFFFF}, s);
        m_fill(32'h840, 4, 8'hD2);
        wait_done(cyc);
        chk_mem("R11");
    endtask

    task automatic t_stall();
        int s, cyc;
        set_colour(8'h99);
        bus_wr(1'b1, {20'h00900, 3'b100}, {3'b000, 5'd11, 24'hFFFFFF}, s);
        bus_wr(1'b1, {20'h00980, 3'b100}, {3'b000, 5'd5, 24'h000900}, s);
        chk(s == 12, "R8", "start stall cycles", s, 12);
        m_fill(32'h900, 12, 8'h99);
        m_copy(32'h980, 32'h900, 6);
        wait_done(cyc);
        chk(cyc == 13, "R8", "second op completion", cyc, 13);
        chk(dirty_addr == 20'h00980, "R8", "second op dirty addr", dirty_addr, 20'h980);
        chk_mem("R8");
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'((i * 7 + 3) & 255);
            exp_mem[i] = 8'((i * 7 + 3) & 255);
        end
        pm_rdata = 8'h0;
        wr_cnt = 0; rd_cnt = 0; checks = 0; fails = 0;
        rst_n = 1'b0; reg_wr = 1'b0; reg_win = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_colour_only();
        t_stipple(32'h100, 32'h80000001, 8'hAB);
        t_stipple(32'h200, 32'hF0F03C5A, 8'h5C);
        t_stipple(32'h300, 32'h00000000, 8'h11);
        t_stipple(32'hFFFF0, 32'hFFFFFFFF, 8'h3E);
        t_fill(32'h400, 10, 8'h77);
        t_fill(32'h480, 32, 8'h66);
        t_fill(32'h4F0, 1, 8'h55);
        t_copy(32'h500, 24'h000040, 16);
        t_copy(32'h605, 24'h000600, 20);
        t_copy(32'h700, 24'h1000C0, 8);
        t_copy(32'hA00, 24'h000010, 32);
        t_busy_colour();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8 actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule